// File: doc/BRIEF.md
# Register-Read Target on a Two-Wire Serial Bus

This block is a target on a two-wire serial bus (I2C). It sees the clock line and the data line as inputs and pulls the data line low through one open-drain enable. It never drives the line high. After a START, it takes in a seven-bit target address and a direction bit. If the address matches the block's own address, it acknowledges. A mismatch leaves the block silent until the next START, so any number of targets can share the bus.

A matched target then takes in an eight-bit register index and acknowledges it. Without waiting for a repeated START, it shifts out the eight-bit entry that the index selects from a small internal register array, most significant bit first. It lets go of the line for the master's acknowledge bit and stays released until STOP.

The array is filled through a parallel write port, which is meant for test and bring-up. The bus itself never writes the array. Both bus lines pass through a two-flop synchroniser into the system clock domain, and every decision is taken on the synchronised copies.

Top module: `i2c_reg_responder`

## Requirements
- R1: After a START, the block takes eight bits on rising SCL edges, first bit = address bit 6, eighth bit = direction bit. If the first seven bits equal OWN_ADDR, it pulls SDA low during the ninth clock, whatever the direction bit is.
- R2: If the seven address bits differ from OWN_ADDR, sda_oe stays 0 until the next START. This includes the ninth clock and every later clock.
- R3: After an address acknowledge, the block takes an eight-bit index (MSB first) and pulls SDA low during the ninth clock of that byte.
- R4: After the index acknowledge, the block puts the selected entry on SDA, MSB first, one bit per SCL clock. A 0 bit means sda_oe=1 and a 1 bit means sda_oe=0.
- R5: An index of ENTRIES or above returns the byte 0x00.
- R6: sda_oe changes only while the synchronised SCL is low.
- R7: After the eighth data bit, the block releases SDA for the master's acknowledge. It does not drive again, on any further SCL clock, until a START.
- R8: A STOP (SDA rising while SCL is high) returns the block to idle with SDA released, and a following transfer behaves normally.
- R9: A START (SDA falling while SCL is high) in any state abandons the current transfer and begins a new address byte.
- R10: When ld_we=1 on a clock edge, ld_data is written into the entry at ld_addr. Index n reads entry n; for example, index 25 returns entry 25.
- R11: While rst_n is low, and right after reset, sda_oe is 0 and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line as seen on the bus |
| sda_i | input | 1 | Bus data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| ld_we | input | 1 | Preload write enable |
| ld_addr | input | $clog2(ENTRIES) | Preload entry number |
| ld_data | input | 8 | Preload entry value |

## Verification
Each bus event reaches the control logic two system clocks after it appears at the pins, because of the synchroniser. Any new value of sda_oe follows on the next edge, so a falling SCL produces a new SDA drive three clocks later. The bench master holds SCL low for sixteen clocks before it raises SCL. It changes its own data eight clocks into the low phase and samples the bus at the end of a sixteen-clock high phase. Every acknowledge and data bit is therefore read long after the design has settled.

The bench pushes the expected acknowledges, data byte and post-acknowledge idle byte into a queue before each transfer. The observed values are compared in order once the transfer ends.

// File: rtl/i2c_resp_pkg.sv
package i2c_resp_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR,
        S_AACK,
        S_INDEX,
        S_IACK,
        S_SEND,
        S_MACK,
        S_HOLD,
        S_IGNORE
    } resp_state_e;

    typedef struct packed {
        resp_state_e        st;
        logic [CNT_W-1:0]   cnt;
        logic [BYTE_W-1:0]  sh;
        logic [BYTE_W-1:0]  idx;
        logic [BYTE_W-1:0]  tx;
        logic               oe;
    } resp_regs_t;

    localparam resp_regs_t REGS_RST = '{
        st:  S_IDLE,
        cnt: '0,
        sh:  '0,
        idx: '0,
        tx:  '0,
        oe:  1'b0
    };

endpackage

// File: rtl/resp_line_sync.sv
module resp_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_pipe_q, sda_pipe_q;
    logic              scl_prev_q, sda_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe_q <= '1;
            sda_pipe_q <= '1;
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_pipe_q <= {scl_pipe_q[STAGES-2:0], scl_i};
            sda_pipe_q <= {sda_pipe_q[STAGES-2:0], sda_i};
            scl_prev_q <= scl_pipe_q[STAGES-1];
            sda_prev_q <= sda_pipe_q[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe_q[STAGES-1];
    assign sda_s     = sda_pipe_q[STAGES-1];
    assign scl_rise  = scl_s & ~scl_prev_q;
    assign scl_fall  = ~scl_s & scl_prev_q;
    // data edge while clock stays high on both samples
    assign start_det = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
    assign stop_det  = scl_s & scl_prev_q & ~sda_prev_q & sda_s;

endmodule

// File: rtl/resp_reg_array.sv
module resp_reg_array #(
    parameter  int ENTRIES = 32,
    parameter  int DATA_W  = 8,
    parameter  int IDX_W   = 8,
    localparam int AW      = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem_q [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mem_q[g] <= '0;
            else if (wr_en && wr_addr == AW'(g))
                mem_q[g] <= wr_data;
        end
    end

    // indices outside the array fall through to zero
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < ENTRIES; i++)
            if (rd_idx == IDX_W'(i))
                rd_data = mem_q[i];
    end

endmodule

// File: rtl/i2c_reg_responder.sv
module i2c_reg_responder
    import i2c_resp_pkg::*;
#(
    parameter logic [6:0] OWN_ADDR    = 7'h2A,
    parameter int         ENTRIES     = 32,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       scl_i,
    input  logic                       sda_i,
    output logic                       sda_oe,
    input  logic                       ld_we,
    input  logic [$clog2(ENTRIES)-1:0] ld_addr,
    input  logic [BYTE_W-1:0]          ld_data
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [BYTE_W-1:0] rd_data;
    resp_regs_t r_q, r_d;

    resp_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    resp_reg_array #(
        .ENTRIES (ENTRIES),
        .DATA_W  (BYTE_W),
        .IDX_W   (BYTE_W)
    ) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ld_we),
        .wr_addr (ld_addr),
        .wr_data (ld_data),
        .rd_idx  (r_q.idx),
        .rd_data (rd_data)
    );

    always_comb begin
        r_d = r_q;
        if (stop_det) begin
            r_d.st  = S_IDLE;
            r_d.oe  = 1'b0;
            r_d.cnt = '0;
        end else if (start_det) begin
            r_d.st  = S_ADDR;
            r_d.oe  = 1'b0;
            r_d.cnt = '0;
            r_d.sh  = '0;
        end else begin
            unique case (r_q.st)
                S_ADDR, S_INDEX: begin
                    if (scl_rise && r_q.cnt < LAST_BIT) begin
                        r_d.sh  = {r_q.sh[BYTE_W-2:0], sda_s};
                        r_d.cnt = r_q.cnt + 1'b1;
                    end else if (scl_fall && r_q.cnt == LAST_BIT) begin
                        if (r_q.st == S_INDEX) begin
                            r_d.st  = S_IACK;
                            r_d.idx = r_q.sh;
                            r_d.oe  = 1'b1;
                        end else if (r_q.sh[BYTE_W-1:1] == OWN_ADDR) begin
                            r_d.st = S_AACK;
                            r_d.oe = 1'b1;
                        end else begin
                            r_d.st = S_IGNORE;
                        end
                    end
                end
                S_AACK: begin
                    if (scl_fall) begin
                        r_d.st  = S_INDEX;
                        r_d.oe  = 1'b0;
                        r_d.cnt = '0;
                    end
                end
                S_IACK: begin
                    if (scl_fall) begin
                        r_d.st  = S_SEND;
                        r_d.tx  = rd_data;
                        r_d.oe  = ~rd_data[BYTE_W-1];
                        r_d.cnt = '0;
                    end
                end
                S_SEND: begin
                    if (scl_rise) begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end else if (scl_fall) begin
                        if (r_q.cnt == LAST_BIT) begin
                            r_d.st = S_MACK;
                            r_d.oe = 1'b0;
                        end else begin
                            r_d.tx = {r_q.tx[BYTE_W-2:0], 1'b0};
                            r_d.oe = ~r_q.tx[BYTE_W-2];
                        end
                    end
                end
                S_MACK: begin
                    if (scl_rise)
                        r_d.st = S_HOLD;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            r_q <= REGS_RST;
        else
            r_q <= r_d;
    end

    assign sda_oe = r_q.oe;

endmodule

// File: rtl/resp_checker.sv
module resp_checker
    import i2c_resp_pkg::*;
#(
    parameter logic [6:0] OWN_ADDR = 7'h2A
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sda_oe,
    input logic              scl_s,
    input logic              start_det,
    input logic              stop_det,
    input resp_state_e       st,
    input logic [BYTE_W-1:0] sh
);

    // R1: acknowledge phase only entered with a matching address
    a_r1_ack_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_AACK) |-> (sh[BYTE_W-1:1] == OWN_ADDR));

    // R2: a non-addressed target keeps the line released
    a_r2_quiet_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IGNORE) |-> !sda_oe);

    // R6: drive changes only while synchronised clock is low
    a_r6_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);

    // R7: released for the master acknowledge and afterwards
    a_r7_release_tail: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_MACK || st == S_HOLD) |-> !sda_oe);

    // R8: stop returns to idle, released
    a_r8_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (st == S_IDLE && !sda_oe));

    // R9: start restarts address reception
    a_r9_start_restart: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (st == S_ADDR));

endmodule

bind i2c_reg_responder resp_checker #(.OWN_ADDR(OWN_ADDR)) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_oe    (sda_oe),
    .scl_s     (scl_s),
    .start_det (start_det),
    .stop_det  (stop_det),
    .st        (r_q.st),
    .sh        (r_q.sh)
);

// File: tb/i2c_reg_responder_bench.sv
module i2c_reg_responder_bench;

    localparam logic [6:0] OWN = 7'h2A;
    localparam int NENT = 32;

    typedef struct {
        logic       aack;
        logic       iack;
        logic [7:0] data;
        logic [7:0] hold;
        string      tag;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe;
    logic ld_we = 1'b0;
    logic [4:0] ld_addr = '0;
    logic [7:0] ld_data = '0;
    wire  sda_bus = m_sda & ~sda_oe;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    bit watch_quiet = 0;
    int quiet_hits = 0;
    int drive_viol = 0;
    logic oe_prev = 1'b0;
    logic scl_prev = 1'b1;
    logic [7:0] mdl [NENT];
    item_t exp_q[$];
    item_t obs_q[$];

    always #2.5 clk = ~clk;

    i2c_reg_responder #(.OWN_ADDR(OWN)) u_i2c_reg_responder (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl),
        .sda_i   (sda_bus),
        .sda_oe  (sda_oe),
        .ld_we   (ld_we),
        .ld_addr (ld_addr),
        .ld_data (ld_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, expv);
        end
    endtask

    // R6 monitor and R2 quiet window
    always @(posedge clk) begin
        if (rst_n && sda_oe !== oe_prev && (scl || scl_prev))
            drive_viol++;
        if (watch_quiet && sda_oe)
            quiet_hits++;
        oe_prev  <= sda_oe;
        scl_prev <= scl;
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_cycle(input logic b, output logic got);
        wait_n(8);  m_sda = b;
        wait_n(8);  scl = 1'b1;
        wait_n(16); got = sda_bus;
        scl = 1'b0;
    endtask

    task automatic bus_start();
        wait_n(8);  m_sda = 1'b1;
        wait_n(8);  scl = 1'b1;
        wait_n(16); m_sda = 1'b0;
        wait_n(16); scl = 1'b0;
    endtask

    task automatic bus_stop();
        wait_n(8);  m_sda = 1'b0;
        wait_n(8);  scl = 1'b1;
        wait_n(16); m_sda = 1'b1;
        wait_n(16);
    endtask

    task automatic preload(input int a, input logic [7:0] v);
        @(negedge clk);
        ld_we = 1'b1; ld_addr = 5'(a); ld_data = v;
        mdl[a] = v;
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    // driver: pushes expectation, runs the transfer, hands result to monitor
    task automatic run(input logic [6:0] a, input logic rw, input logic [7:0] idx,
                       input int abort_bits, input string tag);
        item_t e, o;
        logic g;
        logic [7:0] abyte;
        bit match;
        match  = (a == OWN);
        e.aack = match;
        e.iack = match;
        e.data = match ? ((idx < NENT) ? mdl[idx] : 8'h00) : 8'hFF;
        e.hold = 8'hFF;
        e.tag  = tag;
        exp_q.push_back(e);
        abyte = {a, rw};
        o.tag = tag;
        bus_start();
        if (abort_bits > 0) begin
            for (int i = 0; i < abort_bits; i++) bit_cycle(abyte[7-i], g);
            bus_start();
        end
        watch_quiet = !match;
        for (int i = 7; i >= 0; i--) bit_cycle(abyte[i], g);
        bit_cycle(1'b1, g); o.aack = ~g;
        for (int i = 7; i >= 0; i--) bit_cycle(idx[i], g);
        bit_cycle(1'b1, g); o.iack = ~g;
        for (int i = 7; i >= 0; i--) begin bit_cycle(1'b1, g); o.data[i] = g; end
        bit_cycle(1'b0, g);
        for (int i = 7; i >= 0; i--) begin bit_cycle(1'b1, g); o.hold[i] = g; end
        bus_stop();
        watch_quiet = 0;
        obs_q.push_back(o);
    endtask

    // monitor: compare in order
    initial begin
        forever begin
            @(negedge clk);
            while (obs_q.size() > 0 && exp_q.size() > 0) begin
                item_t e, o;
                e = exp_q.pop_front();
                o = obs_q.pop_front();
                chk(o.aack == e.aack, {e.tag, " addr ack"}, o.aack, e.aack);
                chk(o.iack == e.iack, {e.tag, " index ack"}, o.iack, e.iack);
                chk(o.data == e.data, {e.tag, " data"}, o.data, e.data);
                chk(o.hold == e.hold, {e.tag, " R7 released after data"}, o.hold, e.hold);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog expired act=0 exp=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NENT; i++) mdl[i] = 8'h00;
        wait_n(4);
        chk(sda_oe == 1'b0, "R11 released during reset", sda_oe, 0);
        rst_n = 1'b1;
        wait_n(4);
        chk(sda_oe == 1'b0, "R11 released after reset", sda_oe, 0);

        // R11: entries read zero before any preload
        run(OWN, 1'b0, 8'd7, 0, "R11 R4 unloaded entry");

        // R10: preload every entry with a computed pattern
        for (int i = 0; i < NENT; i++) preload(i, 8'((i * 37 + 11) ^ (i << 3)));
        preload(5, 8'hA5);
        preload(31, 8'hFF);
        preload(0, 8'h00);

        run(OWN, 1'b0, 8'd5,  0, "R1 R3 R4 index5");
        run(OWN, 1'b0, 8'd25, 0, "R10 R4 index25");
        run(OWN, 1'b0, 8'd0,  0, "R4 all-zero entry");
        run(OWN, 1'b0, 8'd31, 0, "R4 all-one entry");
        run(OWN, 1'b1, 8'd3,  0, "R1 direction bit set");
        run(OWN, 1'b0, 8'd32, 0, "R5 index 32");
        run(OWN, 1'b0, 8'd255, 0, "R5 index 255");

        // R2: other targets addressed
        run(7'h2B, 1'b0, 8'd5, 0, "R2 addr differs lsb");
        run(7'h55, 1'b1, 8'd1, 0, "R2 addr differs");
        chk(quiet_hits == 0, "R2 no drive on mismatch", quiet_hits, 0);

        // R9: START after part of an address byte
        run(OWN, 1'b0, 8'd9, 4, "R9 restart after 4 bits");
        run(7'h2B, 1'b0, 8'd9, 6, "R9 R2 restart then mismatch");

        // R8: released after stop, next transfer normal
        wait_n(4);
        chk(sda_oe == 1'b0, "R8 released after STOP", sda_oe, 0);
        preload(25, 8'h3C);
        run(OWN, 1'b0, 8'd25, 0, "R8 R10 rewritten index25");

        wait_n(20);
        chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
        chk(drive_viol == 0, "R6 drive change with SCL high", drive_viol, 0);

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule